// File: doc/BRIEF.md
# ADC Scan Result DMA Sequencer

This block moves analog-to-digital conversion results into the register file without help from the CPU, and it also steps the converter through a scan of its analog inputs. When the converter reports that a conversion has finished, the sequencer takes the 10-bit result and the number of the input that produced it. It asks the CPU for the bus, writes the result as two bytes at a slot set aside for that input, and hands the bus back. It then points the converter at the next input and starts that input's conversion.

When the finished input is the last one in the scan, the sequencer goes back to input 0 and restarts there. At that point it can also raise an interrupt that marks a complete scan. Software sets three things: the highest input to scan, the base address of the result area, and whether the end-of-scan interrupt is on. A result that arrives while a transfer is still in progress is recorded in a sticky overrun flag. It does not disturb the transfer already under way.

Top module: `adc_scan_dma`

## Requirements
- R1: While reset is high, bus_req, rf_we, adc_start, irq and overrun are 0. On the first clock edge after reset is released, adc_start goes high for exactly one cycle with adc_sel = 0.
- R2: When adc_done is sampled high while the sequencer is idle, bus_req is 1 from the next cycle. No register-file write happens until bus_ack is sampled high. The first write appears in the cycle after that sample.
- R3: The first write puts result bits [9:2] at address base + 2·n, where n is the adc_chan value captured with adc_done. The write in the next cycle puts {result[1:0], 6'b000000} at base + 2·n + 1. Addresses wrap modulo 4096.
- R4: In the cycle after the low-byte write, bus_req is 0, rf_we is 0 and adc_start is 1. adc_start is high for that single cycle only.
- R5: If n is below cfg_last_ch, adc_sel equals n + 1 when that restart pulse is issued.
- R6: If n is equal to or above cfg_last_ch, adc_sel is 0 when that restart pulse is issued.
- R7: irq is a one-cycle pulse that comes with the restart pulse only when R6 applies and cfg_irq_en is 1. It stays 0 when cfg_irq_en is 0 and after every input that does not wrap the scan.
- R8: adc_done seen while a transfer is pending sets overrun. overrun then stays 1 until reset. The pending transfer still writes the result and address captured first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_last_ch | input | CH_W | Highest input number in the scan |
| cfg_base | input | ADDR_W | Register-file address of input 0's high byte |
| cfg_irq_en | input | 1 | Enables the end-of-scan interrupt |
| adc_done | input | 1 | Conversion finished strobe |
| adc_result | input | RES_W | Conversion result |
| adc_chan | input | CH_W | Input that produced the result |
| adc_start | output | 1 | One-cycle start-conversion pulse |
| adc_sel | output | CH_W | Input selected for the next conversion |
| bus_req | output | 1 | Bus request to the CPU |
| bus_ack | input | 1 | Bus grant from the CPU |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | ADDR_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| irq | output | 1 | End-of-scan interrupt pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with CH_W = 3, which is narrower than the default. With cfg_last_ch set to 3, input number 5 lies above the scan limit, so the R6 rule "equal to or above" is exercised by a reachable value, not only by the exact-match case. RES_W, DATA_W and ADDR_W keep their defaults of 10, 8 and 12. A base of 0xFFE with input 1 then places both result bytes past the top of the 12-bit space, so the modulo-4096 address wrap is checked. Grant delays from zero to three cycles show that the write never starts ahead of the grant.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    ST_BOOT,   // first cycle out of reset: kick input 0
    ST_KICK,   // start pulse on the ADC
    ST_IDLE,   // waiting for a finished conversion
    ST_REQ,    // bus requested, waiting for the grant
    ST_WRH,    // high byte on the write port
    ST_WRL     // low byte on the write port
  } seq_state_e;

endpackage

// File: rtl/adcseq_chan.sv
module adcseq_chan #(
  parameter int CH_W = 4
) (
  input  logic [CH_W-1:0] done_ch,
  input  logic [CH_W-1:0] last_ch,
  output logic [CH_W-1:0] next_ch,
  output logic            wrap
);

  // An input at or above the configured limit closes the scan
  always_comb begin
    wrap    = (done_ch >= last_ch);
    next_ch = wrap ? '0 : done_ch + CH_W'(1);
  end

endmodule

// File: rtl/adcseq_fmt.sv
module adcseq_fmt #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  parameter int CH_W   = 4
) (
  input  logic [RES_W-1:0]  res,
  input  logic [CH_W-1:0]   ch,
  input  logic [ADDR_W-1:0] base,
  output logic [DATA_W-1:0] hi_byte,
  output logic [DATA_W-1:0] lo_byte,
  output logic [ADDR_W-1:0] hi_addr,
  output logic [ADDR_W-1:0] lo_addr
);

  localparam int LO_BITS = RES_W - DATA_W;
  localparam int PAD     = DATA_W - LO_BITS;
  localparam int OFF_W   = CH_W + 1;

  logic [OFF_W-1:0] slot_off;

  assign hi_byte = res[RES_W-1 -: DATA_W];

  // Remaining result bits are left-justified in the second byte
  generate
    if (PAD > 0) begin : g_pad
      assign lo_byte = {res[LO_BITS-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign lo_byte = res[DATA_W-1:0];
    end
  endgenerate

  // Each input owns two consecutive bytes
  always_comb begin
    slot_off = {ch, 1'b0};
    hi_addr  = base + ADDR_W'(slot_off);
    lo_addr  = hi_addr + ADDR_W'(1);
  end

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_irq_en,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_result,
  input  logic [CH_W-1:0]   adc_chan,
  input  logic              bus_ack,
  // from the formatter and channel stepper
  input  logic [DATA_W-1:0] hi_byte,
  input  logic [DATA_W-1:0] lo_byte,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [CH_W-1:0]   next_ch,
  input  logic              wrap,
  // captured transfer
  output logic [RES_W-1:0]  res_q,
  output logic [CH_W-1:0]   ch_q,
  // registered outputs
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_sel,
  output logic              bus_req,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              irq,
  output logic              overrun
);

  seq_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BOOT;
      res_q     <= '0;
      ch_q      <= '0;
      adc_start <= 1'b0;
      adc_sel   <= '0;
      bus_req   <= 1'b0;
      rf_we     <= 1'b0;
      rf_addr   <= '0;
      rf_wdata  <= '0;
      irq       <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      rf_we     <= 1'b0;
      adc_start <= 1'b0;
      irq       <= 1'b0;
      if (adc_done && state != ST_IDLE) overrun <= 1'b1;
      case (state)
        ST_BOOT: begin
          adc_start <= 1'b1;
          adc_sel   <= '0;
          state     <= ST_KICK;
        end
        ST_KICK: state <= ST_IDLE;
        ST_IDLE: begin
          if (adc_done) begin
            res_q   <= adc_result;
            ch_q    <= adc_chan;
            bus_req <= 1'b1;
            state   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_ack) begin
            rf_we    <= 1'b1;
            rf_addr  <= hi_addr;
            rf_wdata <= hi_byte;
            state    <= ST_WRH;
          end
        end
        ST_WRH: begin
          rf_we    <= 1'b1;
          rf_addr  <= lo_addr;
          rf_wdata <= lo_byte;
          state    <= ST_WRL;
        end
        ST_WRL: begin
          bus_req   <= 1'b0;
          adc_start <= 1'b1;
          adc_sel   <= next_ch;
          irq       <= wrap && cfg_irq_en;
          state     <= ST_KICK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  we_under_req_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> bus_req);

  // R2
  grant_before_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_we) |-> $past(bus_ack));

  // R3
  byte_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_we) |=> (rf_we && rf_addr == $past(rf_addr) + ADDR_W'(1)));

  // R4
  release_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> (adc_start && !rf_we));

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  // R7
  irq_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (adc_start && adc_sel == '0));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

endmodule

// File: rtl/adc_scan_dma.sv
module adc_scan_dma #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   cfg_last_ch,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_irq_en,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_result,
  input  logic [CH_W-1:0]   adc_chan,
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_sel,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              irq,
  output logic              overrun
);

  logic [RES_W-1:0]  res_q;
  logic [CH_W-1:0]   ch_q;
  logic [DATA_W-1:0] hi_byte, lo_byte;
  logic [ADDR_W-1:0] hi_addr, lo_addr;
  logic [CH_W-1:0]   next_ch;
  logic              wrap;

  adcseq_fmt #(
    .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) u_fmt (
    .res(res_q), .ch(ch_q), .base(cfg_base),
    .hi_byte(hi_byte), .lo_byte(lo_byte),
    .hi_addr(hi_addr), .lo_addr(lo_addr)
  );

  adcseq_chan #(.CH_W(CH_W)) u_chan (
    .done_ch(ch_q), .last_ch(cfg_last_ch),
    .next_ch(next_ch), .wrap(wrap)
  );

  adcseq_ctrl #(
    .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cfg_irq_en(cfg_irq_en),
    .adc_done(adc_done), .adc_result(adc_result), .adc_chan(adc_chan),
    .bus_ack(bus_ack),
    .hi_byte(hi_byte), .lo_byte(lo_byte),
    .hi_addr(hi_addr), .lo_addr(lo_addr),
    .next_ch(next_ch), .wrap(wrap),
    .res_q(res_q), .ch_q(ch_q),
    .adc_start(adc_start), .adc_sel(adc_sel), .bus_req(bus_req),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .irq(irq), .overrun(overrun)
  );

endmodule

// File: tb/sim_adc_scan_dma.sv
module sim_adc_scan_dma;

  localparam int RES_W  = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 12;
  localparam int CH_W   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CH_W-1:0]   cfg_last_ch = 3'd3;
  logic [ADDR_W-1:0] cfg_base = 12'h120;
  logic              cfg_irq_en = 1'b1;
  logic              adc_done = 1'b0;
  logic [RES_W-1:0]  adc_result = '0;
  logic [CH_W-1:0]   adc_chan = '0;
  logic              adc_start;
  logic [CH_W-1:0]   adc_sel;
  logic              bus_req;
  logic              bus_ack = 1'b0;
  logic              rf_we;
  logic [ADDR_W-1:0] rf_addr;
  logic [DATA_W-1:0] rf_wdata;
  logic              irq;
  logic              overrun;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adc_scan_dma #(
    .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_last_ch(cfg_last_ch), .cfg_base(cfg_base),
    .cfg_irq_en(cfg_irq_en), .adc_done(adc_done), .adc_result(adc_result),
    .adc_chan(adc_chan), .adc_start(adc_start), .adc_sel(adc_sel),
    .bus_req(bus_req), .bus_ack(bus_ack), .rf_we(rf_we), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .irq(irq), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Vector: chan | result | grant delay | irq enable | expected sel | expected irq
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {3'd0, 10'h3FF, 4'd0, 1'b1, 3'd1, 1'b0},
    {3'd1, 10'h001, 4'd2, 1'b1, 3'd2, 1'b0},
    {3'd2, 10'h2AA, 4'd1, 1'b1, 3'd3, 1'b0},
    {3'd3, 10'h155, 4'd0, 1'b1, 3'd0, 1'b1},
    {3'd3, 10'h200, 4'd3, 1'b0, 3'd0, 1'b0},
    {3'd5, 10'h0C3, 4'd0, 1'b1, 3'd0, 1'b1}
  };

  // One complete transfer; expected bytes and addresses follow R3
  task automatic xfer(input logic [CH_W-1:0] ch, input logic [RES_W-1:0] res,
                      input int dly, input logic en,
                      input logic [CH_W-1:0] exp_sel, input logic exp_irq);
    logic [ADDR_W-1:0] a;
    a = cfg_base + ADDR_W'({ch, 1'b0});
    @(negedge clk);
    cfg_irq_en = en; adc_chan = ch; adc_result = res; adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
    chk("R2 request raised", 32'(bus_req), 32'd1);
    chk("R2 no write before grant", 32'(rf_we), 32'd0);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R2 hold while ungranted", 32'({bus_req, rf_we}), 32'b10);
    end
    bus_ack = 1'b1;
    @(negedge clk);
    chk("R3 high write enable", 32'(rf_we), 32'd1);
    chk("R3 high address", 32'(rf_addr), 32'(a));
    chk("R3 high byte", 32'(rf_wdata), 32'(res[9:2]));
    @(negedge clk);
    chk("R3 low write enable", 32'(rf_we), 32'd1);
    chk("R3 low address", 32'(rf_addr), 32'(a + ADDR_W'(1)));
    chk("R3 low byte", 32'(rf_wdata), 32'({res[1:0], 6'b0}));
    @(negedge clk);
    bus_ack = 1'b0;
    chk("R4 release and restart", 32'({bus_req, rf_we, adc_start}), 32'b001);
    chk("R5/R6 next select", 32'(adc_sel), 32'(exp_sel));
    chk("R7 irq at restart", 32'(irq), 32'(exp_irq));
    @(negedge clk);
    chk("R4 start single cycle", 32'(adc_start), 32'd0);
    chk("R7 irq single cycle", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", 32'({bus_req, rf_we, adc_start, irq, overrun}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 boot start", 32'(adc_start), 32'd1);
    chk("R1 boot select", 32'(adc_sel), 32'd0);
    @(negedge clk);
    chk("R1 boot pulse ends", 32'(adc_start), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][21:19], VEC[i][18:9], int'(VEC[i][8:5]), VEC[i][4],
           VEC[i][3:1], VEC[i][0]);
    end
    chk("R8 no overrun yet", 32'(overrun), 32'd0);

    // R3: address wraps past the top of the space
    cfg_base = 12'hFFE;
    xfer(3'd1, 10'h18E, 0, 1'b1, 3'd2, 1'b0);
    cfg_base = 12'h120;

    // R8: second strobe during a pending transfer
    @(negedge clk);
    adc_chan = 3'd2; adc_result = 10'h3C7; adc_done = 1'b1;
    @(negedge clk);
    adc_chan = 3'd0; adc_result = 10'h000; // other values on the second strobe
    chk("R8 request raised", 32'(bus_req), 32'd1);
    @(negedge clk);
    adc_done = 1'b0;
    chk("R8 overrun set", 32'(overrun), 32'd1);
    bus_ack = 1'b1;
    @(negedge clk);
    chk("R8 original high address", 32'(rf_addr), 32'(12'h124));
    chk("R8 original high byte", 32'(rf_wdata), 32'(8'hF1));
    @(negedge clk);
    chk("R8 original low byte", 32'(rf_wdata), 32'(8'hC0));
    @(negedge clk);
    bus_ack = 1'b0;
    chk("R8 original select", 32'(adc_sel), 32'd3);
    @(negedge clk);
    xfer(3'd0, 10'h2D4, 1, 1'b1, 3'd1, 1'b0);
    chk("R8 overrun sticky", 32'(overrun), 32'd1);

    // R8: reset clears the flag
    rst = 1'b1;
    @(negedge clk);
    chk("R8 overrun cleared by reset", 32'(overrun), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 boot start after reset", 32'({adc_start, 5'(adc_sel)}), 32'b100000);
    report();
  end

endmodule